// File: doc/BRIEF.md
# Instruction Word Decoder and Operand Fetch

This block sits between an instruction word source and the execute stage of a small 16-bit processor with a 24-bit address space. Instruction words arrive one at a time over a valid/ready handshake. The first word of each instruction carries an opcode, an addressing mode and register fields. The block then takes the extension words that the addressing mode calls for. Zero, one or two words follow, and the mode alone sets the count, whatever the opcode is.

Once the last word is in, the block presents one decoded record. The record holds the opcode, the mode, the two register indices, a 16-bit constant, a 24-bit effective address and an illegal flag. The record stays on the outputs until the consumer takes it. No further words are taken while it is waiting. Direct-local addresses get their upper byte from the program-counter high byte. That byte is sampled on the cycle the opcode word is accepted.

Top module: `instr_decoder`

## Requirements
- R1: The first word splits as opcode = bits 15:10, mode = bits 9:8, destination register = bits 7:4, source register = bits 3:0; all four appear unchanged on the record.
- R2: Mode 0 (constant) takes one extension word; it appears on `dec_imm_o`, and `dec_addr_o` is zero.
- R3: Mode 1 (local address) takes one extension word; `dec_addr_o` = {`pc_hi_i` as sampled with the opcode word, extension word}, and `dec_imm_o` is zero.
- R4: Mode 2 (far address) takes two extension words; `dec_addr_o` = {first word bits 7:0, second word}, `dec_imm_o` is zero, and a nonzero upper byte in the first extension word sets the illegal flag.
- R5: Mode 3 (register or indirect) takes no extension word; `dec_imm_o` and `dec_addr_o` are zero.
- R6: The word 16'hFFFF is the legal no-operation instruction; any other word with opcode 6'h3F is illegal.
- R7: Opcodes outside the defined set {02, 04, 08, 11 to 1D, 20 to 29, 30 to 39, 3F} (hex) set the illegal flag.
- R8: A mode not allowed for the opcode sets the illegal flag. The allowed modes are: 02 and 04 take any mode. 11, 13, 15, 16 and 17 take modes 0 and 3. 20 to 29 and 30 take modes 1, 2 and 3. 31 takes modes 1 and 2. 08, 12, 14, 18 to 1D and 32 to 39 take mode 3 only.
- R9: Reserved bits that are nonzero set the illegal flag. This covers bits 3:0 of the one-register opcodes (02, 04, 12, 14, 18 to 1D, 20 to 25, 34 to 39) and bits 7:0 of the no-register opcodes (30 to 33).
- R10: While `dec_valid_o` is high and `dec_ready_i` is low, the record holds stable and `word_ready_o` is low. After the record is accepted, `dec_valid_o` is low and `word_ready_o` is high on the next cycle.
- R11: After reset, `dec_valid_o` is low and `word_ready_o` is high.
- R12: The number of extension words taken depends only on the mode, also for illegal opcodes. `dec_valid_o` rises on the cycle after the last word of the instruction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_valid_i | input | 1 | Instruction word offered |
| word_ready_o | output | 1 | Decoder takes a word this cycle |
| word_i | input | 16 | Instruction word |
| pc_hi_i | input | 8 | Program counter high byte |
| dec_valid_o | output | 1 | Decoded record valid |
| dec_ready_i | input | 1 | Consumer takes the record |
| dec_opcode_o | output | 6 | Opcode |
| dec_mode_o | output | 2 | Addressing mode |
| dec_rd_o | output | 4 | Destination register or flag index |
| dec_rs_o | output | 4 | Source register index |
| dec_imm_o | output | 16 | Constant operand |
| dec_addr_o | output | 24 | Effective address |
| dec_illegal_o | output | 1 | Illegal instruction |

## Verification
The bench aims at each way the record can go wrong.

- **Word count.** It sends illegal opcodes in modes that carry extension words. A decoder that skipped the extension words of illegal opcodes would take the next opcode from the wrong word, and every later record would be wrong.
- **Program-counter byte.** It changes `pc_hi_i` right after the opcode word is accepted. A design that samples the byte late would show the new byte in local addresses.
- **No-operation and reserved bits.** It sends opcode 3F words that are not all ones, nonzero reserved nibbles and bytes, and far-address words with a nonzero upper byte. Missing any of these checks would leave the illegal flag low where it must be high.
- **Hold phase.** It offers junk words while a record is held. A design that took them would change the held record or corrupt the next instruction.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;
  localparam int WORD_W   = 16;
  localparam int OPC_W    = 6;
  localparam int MODE_W   = 2;
  localparam int REG_W    = 4;
  localparam int HI_W     = 8;
  localparam int ADDR_W   = HI_W + WORD_W;
  localparam int NMODES   = 1 << MODE_W;
  localparam logic [WORD_W-1:0] NOP_WORD = '1;
  localparam logic [OPC_W-1:0]  NOP_OPC  = '1;

  typedef enum logic [MODE_W-1:0] {
    MODE_IMM    = 2'd0,
    MODE_LOCAL  = 2'd1,
    MODE_GLOBAL = 2'd2,
    MODE_REG    = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    FMT_NOREG  = 2'd0,
    FMT_ONEREG = 2'd1,
    FMT_TWOREG = 2'd2,
    FMT_UNDEF  = 2'd3
  } fmt_e;

  typedef struct packed {
    logic [NMODES-1:0] modes_ok;
    fmt_e              fmt;
  } op_info_t;

  typedef struct packed {
    logic [OPC_W-1:0]  opcode;
    mode_e             mode;
    logic [REG_W-1:0]  rd;
    logic [REG_W-1:0]  rs;
    logic [WORD_W-1:0] imm;
    logic [ADDR_W-1:0] addr;
    logic              illegal;
  } dec_rec_t;

  function automatic logic [1:0] ext_count(input logic [MODE_W-1:0] m);
    case (m)
      MODE_IMM, MODE_LOCAL: ext_count = 2'd1;
      MODE_GLOBAL:          ext_count = 2'd2;
      default:              ext_count = 2'd0;
    endcase
  endfunction

  // mode mask bit n = mode n allowed
  function automatic op_info_t op_lookup(input logic [OPC_W-1:0] op);
    op_info_t r;
    r = '{modes_ok: '0, fmt: FMT_UNDEF};
    case (op)
      6'h02, 6'h04:
        r = '{modes_ok: 4'b1111, fmt: FMT_ONEREG};
      6'h08:
        r = '{modes_ok: 4'b1000, fmt: FMT_TWOREG};
      6'h11, 6'h13, 6'h15, 6'h16, 6'h17:
        r = '{modes_ok: 4'b1001, fmt: FMT_TWOREG};
      6'h12, 6'h14, 6'h18, 6'h19, 6'h1A, 6'h1B, 6'h1C, 6'h1D,
      6'h34, 6'h35, 6'h36, 6'h37, 6'h38, 6'h39:
        r = '{modes_ok: 4'b1000, fmt: FMT_ONEREG};
      6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25:
        r = '{modes_ok: 4'b1110, fmt: FMT_ONEREG};
      6'h26, 6'h27, 6'h28, 6'h29:
        r = '{modes_ok: 4'b1110, fmt: FMT_TWOREG};
      6'h30:
        r = '{modes_ok: 4'b1110, fmt: FMT_NOREG};
      6'h31:
        r = '{modes_ok: 4'b0110, fmt: FMT_NOREG};
      6'h32, 6'h33:
        r = '{modes_ok: 4'b1000, fmt: FMT_NOREG};
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dec_word_fsm.sv
module dec_word_fsm
  import instr_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  input  logic [WORD_W-1:0] word_i,
  input  logic [HI_W-1:0]   pc_hi_i,
  output logic              rec_valid_o,
  input  logic              rec_ready_i,
  output logic [WORD_W-1:0] w0_o,
  output logic [WORD_W-1:0] e1_o,
  output logic [WORD_W-1:0] e2_o,
  output logic [HI_W-1:0]   pc_hi_o
);
  typedef enum logic [1:0] {S_OPC, S_EXT1, S_EXT2, S_HOLD} state_e;

  state_e            state_q, state_d;
  logic [WORD_W-1:0] w0_q, e1_q, e2_q;
  logic [HI_W-1:0]   pc_q;
  logic              take;
  logic [1:0]        n_ext;

  assign word_ready_o = (state_q != S_HOLD);
  assign rec_valid_o  = (state_q == S_HOLD);
  assign take         = word_valid_i && word_ready_o;
  assign n_ext        = ext_count(word_i[WORD_W-OPC_W-1 -: MODE_W]);

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_OPC:  if (take) state_d = (n_ext == 2'd0) ? S_HOLD : S_EXT1;
      S_EXT1: if (take) state_d = (ext_count(w0_q[WORD_W-OPC_W-1 -: MODE_W]) == 2'd2) ? S_EXT2 : S_HOLD;
      S_EXT2: if (take) state_d = S_HOLD;
      S_HOLD: if (rec_ready_i) state_d = S_OPC;
      default: state_d = S_OPC;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_OPC;
      w0_q    <= '0;
      e1_q    <= '0;
      e2_q    <= '0;
      pc_q    <= '0;
    end else begin
      state_q <= state_d;
      if (take) begin
        case (state_q)
          S_OPC: begin
            w0_q <= word_i;
            pc_q <= pc_hi_i;
          end
          S_EXT1:  e1_q <= word_i;
          S_EXT2:  e2_q <= word_i;
          default: ;
        endcase
      end
    end
  end

  assign w0_o    = w0_q;
  assign e1_o    = e1_q;
  assign e2_o    = e2_q;
  assign pc_hi_o = pc_q;
endmodule

// File: rtl/dec_legality.sv
module dec_legality
  import instr_dec_pkg::*;
(
  input  logic [WORD_W-1:0] w0_i,
  input  logic [HI_W-1:0]   e1_hi_i,
  output logic              illegal_o
);
  logic [OPC_W-1:0]  op;
  logic [MODE_W-1:0] md;
  op_info_t          info;

  assign op   = w0_i[WORD_W-1 -: OPC_W];
  assign md   = w0_i[WORD_W-OPC_W-1 -: MODE_W];
  assign info = op_lookup(op);

  always_comb begin
    illegal_o = 1'b0;
    if (op == NOP_OPC) begin
      illegal_o = (w0_i != NOP_WORD);
    end else begin
      if (info.fmt == FMT_UNDEF)                            illegal_o = 1'b1;
      if (!info.modes_ok[md])                               illegal_o = 1'b1;
      if (info.fmt == FMT_ONEREG && w0_i[REG_W-1:0] != '0)  illegal_o = 1'b1;
      if (info.fmt == FMT_NOREG && w0_i[2*REG_W-1:0] != '0) illegal_o = 1'b1;
      if (md == MODE_GLOBAL && e1_hi_i != '0)               illegal_o = 1'b1;
    end
  end
endmodule

// File: rtl/dec_assemble.sv
module dec_assemble
  import instr_dec_pkg::*;
(
  input  logic [WORD_W-1:0] w0_i,
  input  logic [WORD_W-1:0] e1_i,
  input  logic [WORD_W-1:0] e2_i,
  input  logic [HI_W-1:0]   pc_hi_i,
  input  logic              illegal_i,
  output dec_rec_t          rec_o
);
  mode_e md;
  assign md = mode_e'(w0_i[WORD_W-OPC_W-1 -: MODE_W]);

  always_comb begin
    rec_o.opcode  = w0_i[WORD_W-1 -: OPC_W];
    rec_o.mode    = md;
    rec_o.rd      = w0_i[2*REG_W-1 -: REG_W];
    rec_o.rs      = w0_i[REG_W-1:0];
    rec_o.illegal = illegal_i;
    rec_o.imm     = '0;
    rec_o.addr    = '0;
    case (md)
      MODE_IMM:    rec_o.imm  = e1_i;
      MODE_LOCAL:  rec_o.addr = {pc_hi_i, e1_i};
      MODE_GLOBAL: rec_o.addr = {e1_i[HI_W-1:0], e2_i};
      default: ;
    endcase
  end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import instr_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  input  logic [WORD_W-1:0] word_i,
  input  logic [HI_W-1:0]   pc_hi_i,
  output logic              dec_valid_o,
  input  logic              dec_ready_i,
  output logic [OPC_W-1:0]  dec_opcode_o,
  output logic [MODE_W-1:0] dec_mode_o,
  output logic [REG_W-1:0]  dec_rd_o,
  output logic [REG_W-1:0]  dec_rs_o,
  output logic [WORD_W-1:0] dec_imm_o,
  output logic [ADDR_W-1:0] dec_addr_o,
  output logic              dec_illegal_o
);
  logic [WORD_W-1:0] w0, e1, e2;
  logic [HI_W-1:0]   pc_hi;
  logic              illegal;
  dec_rec_t          rec;

  dec_word_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_valid_i (word_valid_i),
    .word_ready_o (word_ready_o),
    .word_i       (word_i),
    .pc_hi_i      (pc_hi_i),
    .rec_valid_o  (dec_valid_o),
    .rec_ready_i  (dec_ready_i),
    .w0_o         (w0),
    .e1_o         (e1),
    .e2_o         (e2),
    .pc_hi_o      (pc_hi)
  );

  dec_legality u_legal (
    .w0_i      (w0),
    .e1_hi_i   (e1[WORD_W-1 -: HI_W]),
    .illegal_o (illegal)
  );

  dec_assemble u_asm (
    .w0_i      (w0),
    .e1_i      (e1),
    .e2_i      (e2),
    .pc_hi_i   (pc_hi),
    .illegal_i (illegal),
    .rec_o     (rec)
  );

  assign dec_opcode_o  = rec.opcode;
  assign dec_mode_o    = rec.mode;
  assign dec_rd_o      = rec.rd;
  assign dec_rs_o      = rec.rs;
  assign dec_imm_o     = rec.imm;
  assign dec_addr_o    = rec.addr;
  assign dec_illegal_o = rec.illegal;
endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk
  import instr_dec_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              word_ready_o,
  input logic              dec_valid_o,
  input logic              dec_ready_i,
  input logic [OPC_W-1:0]  dec_opcode_o,
  input logic [MODE_W-1:0] dec_mode_o,
  input logic [REG_W-1:0]  dec_rd_o,
  input logic [REG_W-1:0]  dec_rs_o,
  input logic [WORD_W-1:0] dec_imm_o,
  input logic [ADDR_W-1:0] dec_addr_o,
  input logic              dec_illegal_o
);
  logic [OPC_W+MODE_W+2*REG_W+WORD_W+ADDR_W:0] rec_bus;
  assign rec_bus = {dec_opcode_o, dec_mode_o, dec_rd_o, dec_rs_o, dec_imm_o, dec_addr_o, dec_illegal_o};

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && !dec_ready_i |=> dec_valid_o && $stable(rec_bus)); // R10
  AST_NO_INTAKE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> !word_ready_o); // R10
  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && dec_ready_i |=> !dec_valid_o && word_ready_o); // R10
  AST_IMM_NO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && dec_mode_o == 2'd0 |-> dec_addr_o == '0); // R2
  AST_ADDR_NO_IMM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && (dec_mode_o == 2'd1 || dec_mode_o == 2'd2) |-> dec_imm_o == '0); // R3
  AST_REG_NO_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && dec_mode_o == 2'd3 |-> dec_imm_o == '0 && dec_addr_o == '0); // R5
  AST_NOP_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && dec_opcode_o == NOP_OPC && !dec_illegal_o |-> (&{dec_mode_o, dec_rd_o, dec_rs_o})); // R6
  AST_UNDEF_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && dec_opcode_o == '0 |-> dec_illegal_o); // R7
endmodule

bind instr_decoder instr_decoder_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .word_ready_o  (word_ready_o),
  .dec_valid_o   (dec_valid_o),
  .dec_ready_i   (dec_ready_i),
  .dec_opcode_o  (dec_opcode_o),
  .dec_mode_o    (dec_mode_o),
  .dec_rd_o      (dec_rd_o),
  .dec_rs_o      (dec_rs_o),
  .dec_imm_o     (dec_imm_o),
  .dec_addr_o    (dec_addr_o),
  .dec_illegal_o (dec_illegal_o)
);

// File: tb/tb_instr_decoder.sv
`timescale 1ns/1ps
module tb_instr_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        word_valid_i = 1'b0;
  logic        word_ready_o;
  logic [15:0] word_i = '0;
  logic [7:0]  pc_hi_i = '0;
  logic        dec_valid_o;
  logic        dec_ready_i = 1'b0;
  logic [5:0]  dec_opcode_o;
  logic [1:0]  dec_mode_o;
  logic [3:0]  dec_rd_o, dec_rs_o;
  logic [15:0] dec_imm_o;
  logic [23:0] dec_addr_o;
  logic        dec_illegal_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk_i = ~clk_i;

  instr_decoder dut (.*);

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int model_nwords(input logic [1:0] md);
    if (md == 2'd2) return 2;
    if (md == 2'd3) return 0;
    return 1;
  endfunction

  function automatic logic model_illegal(input logic [15:0] w0, input logic [15:0] e1);
    logic [5:0] op;
    logic [1:0] md;
    logic [3:0] ok;
    int kind; // -1 undefined, 0 no register, 1 one register, 2 two registers
    op = w0[15:10];
    md = w0[9:8];
    ok = 4'b0000;
    kind = -1;
    if (op == 6'h3F) return w0 != 16'hFFFF;
    if (op == 6'h02 || op == 6'h04) begin ok = 4'b1111; kind = 1; end
    else if (op == 6'h08) begin ok = 4'b1000; kind = 2; end
    else if (op == 6'h11 || op == 6'h13 || (op >= 6'h15 && op <= 6'h17)) begin ok = 4'b1001; kind = 2; end
    else if (op == 6'h12 || op == 6'h14 || (op >= 6'h18 && op <= 6'h1D)) begin ok = 4'b1000; kind = 1; end
    else if (op >= 6'h20 && op <= 6'h25) begin ok = 4'b1110; kind = 1; end
    else if (op >= 6'h26 && op <= 6'h29) begin ok = 4'b1110; kind = 2; end
    else if (op == 6'h30) begin ok = 4'b1110; kind = 0; end
    else if (op == 6'h31) begin ok = 4'b0110; kind = 0; end
    else if (op == 6'h32 || op == 6'h33) begin ok = 4'b1000; kind = 0; end
    else if (op >= 6'h34 && op <= 6'h39) begin ok = 4'b1000; kind = 1; end
    if (kind < 0) return 1'b1;
    if (!ok[md]) return 1'b1;
    if (kind == 1 && w0[3:0] != 4'h0) return 1'b1;
    if (kind == 0 && w0[7:0] != 8'h00) return 1'b1;
    if (md == 2'd2 && e1[15:8] != 8'h00) return 1'b1;
    return 1'b0;
  endfunction

  task automatic send_word(input logic [15:0] w);
    repeat ($urandom % 3) @(negedge clk_i);
    word_valid_i = 1'b1;
    word_i = w;
    while (!word_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    word_valid_i = 1'b0;
  endtask

  task automatic run_instr(input logic [15:0] w0, input logic [15:0] e1, input logic [15:0] e2,
                           input logic [7:0] pc, input int hold, input string tag);
    int n;
    logic [1:0]  md;
    logic [15:0] ei, ee;
    logic [15:0] x_imm;
    logic [23:0] x_addr;
    md = w0[9:8];
    n = model_nwords(md);
    pc_hi_i = pc;
    send_word(w0);
    pc_hi_i = ~pc; // R3: late change must not reach the address
    if (n > 0) begin
      check({tag, " R12 waiting after opcode"}, dec_valid_o, 1'b0);
      send_word(e1);
    end
    if (n > 1) begin
      check({tag, " R12 waiting after first ext"}, dec_valid_o, 1'b0);
      send_word(e2);
    end
    ei = (n > 0) ? e1 : 16'h0;
    ee = (n > 1) ? e2 : 16'h0;
    x_imm  = (md == 2'd0) ? ei : 16'h0;
    x_addr = (md == 2'd1) ? {pc, ei} : (md == 2'd2) ? {ei[7:0], ee} : 24'h0;
    check({tag, " R12 valid after last word"}, dec_valid_o, 1'b1);
    check({tag, " R1 fields"}, {dec_opcode_o, dec_mode_o, dec_rd_o, dec_rs_o}, w0);
    check({tag, " R2 R3 R4 R5 imm"}, dec_imm_o, x_imm);
    check({tag, " R2 R3 R4 R5 addr"}, dec_addr_o, x_addr);
    check({tag, " R4 R6 R7 R8 R9 illegal"}, dec_illegal_o, model_illegal(w0, ei));
    for (int i = 0; i < hold; i++) begin
      word_valid_i = 1'b1;
      word_i = 16'($urandom);
      @(negedge clk_i);
      check({tag, " R10 held valid"}, dec_valid_o, 1'b1);
      check({tag, " R10 no intake"}, word_ready_o, 1'b0);
      check({tag, " R10 stable"}, {dec_opcode_o, dec_mode_o, dec_rd_o, dec_rs_o, dec_imm_o, dec_addr_o},
            {w0, x_imm, x_addr});
    end
    word_valid_i = 1'b0;
    dec_ready_i = 1'b1;
    @(negedge clk_i);
    dec_ready_i = 1'b0;
    check({tag, " R10 released"}, {dec_valid_o, word_ready_o}, 2'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk_i);
    check("R11 reset valid low", dec_valid_o, 1'b0);
    check("R11 reset ready high", word_ready_o, 1'b1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R11 after reset", {dec_valid_o, word_ready_o}, 2'b01);

    // directed corner cases
    run_instr(16'hFFFF, 16'h0, 16'h0, 8'h12, 0, "R6 nop");
    run_instr(16'hFEFF, 16'h0, 16'h0, 8'h12, 0, "R6 nop bad low");
    run_instr(16'hFC00, 16'hBEEF, 16'h0, 8'h12, 1, "R6 R12 op3F mode0");
    run_instr({6'h00, 2'd2, 8'h00}, 16'h00AB, 16'hCDEF, 8'h44, 0, "R7 R12 undef far");
    run_instr({6'h02, 2'd1, 8'h50}, 16'h1234, 16'h0, 8'hA5, 2, "R3 local");
    run_instr({6'h02, 2'd2, 8'h30}, 16'h007F, 16'h8001, 8'h00, 0, "R4 far");
    run_instr({6'h04, 2'd2, 8'h30}, 16'h017F, 16'h8001, 8'h00, 0, "R4 far hi nonzero");
    run_instr({6'h11, 2'd0, 8'h12}, 16'hFFFF, 16'h0, 8'h00, 0, "R2 add const");
    run_instr({6'h08, 2'd3, 8'hAB}, 16'h0, 16'h0, 8'h00, 3, "R5 move");
    run_instr({6'h12, 2'd3, 8'h31}, 16'h0, 16'h0, 8'h00, 0, "R9 one-reg nibble");
    run_instr({6'h32, 2'd3, 8'h01}, 16'h0, 16'h0, 8'h00, 0, "R9 no-reg byte");
    run_instr({6'h31, 2'd3, 8'h00}, 16'h0, 16'h0, 8'h00, 0, "R8 call indirect");
    run_instr({6'h12, 2'd0, 8'h30}, 16'h5555, 16'h0, 8'h00, 0, "R8 R12 inc const");
    run_instr({6'h28, 2'd1, 8'h9C}, 16'h4000, 16'h0, 8'hFF, 0, "R1 R8 branch local");

    // constrained random
    for (int k = 0; k < 400; k++) begin
      logic [15:0] w0, e1, e2;
      w0 = 16'($urandom);
      if ($urandom % 2) w0[3:0] = 4'h0;
      if ($urandom % 3 == 0) w0[7:0] = 8'h00;
      e1 = 16'($urandom);
      if ($urandom % 4 != 0) e1[15:8] = 8'h00;
      e2 = 16'($urandom);
      run_instr(w0, e1, e2, 8'($urandom), int'($urandom % 3), "rand R1");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule